// File: doc/BRIEF.md
# DSP Dual-Bus Address Generator

This block produces data-memory addresses for DSP transfer operations and computes the pointer updates that follow them. It holds eight pointer and index registers (numbered 2 to 9) plus two modulo windows, one for each side of the paired buses. A decoded operation arrives on a single cycle. The block answers in the same cycle with the effective address or addresses and the write-back values. The pointer registers update on the next clock edge.

There are two access kinds. In paired mode, two word addresses go out together: one on the X bus and one on the Y bus. Each side has its own pointer, its own index and its own modulo window, and the two sides never share a register. In single mode, one address goes out on the shared bus, for a word or a longword. This mode adds a pre-decrement update and does not use modulo wraparound. A configuration write port loads the registers and the window limits.

Top module: `dsp_agu`

## Requirements
- R1: A synchronous reset clears every pointer and index register and all four window limits (start and end for each side) to zero.
- R2: In paired mode, the X address comes from R4 when `x_sel`=0 and from R5 when `x_sel`=1. The Y address comes from R6 when `y_sel`=0 and from R7 when `y_sel`=1. Both addresses are issued with bit 0 forced to 0.
- R3: Each paired side updates by its own code: 0 means no update, 1 means the pointer plus 2, and 2 means the pointer plus its index register (R8 for X, R9 for Y). Code 3 also means no update. The old value is issued, and both sides write back on the same clock edge.
- R4: When `mod_en` is 1 in paired mode, a side's updated value is checked against that side's end limit (unsigned). If it is above the limit, the side's start limit is written instead. Each side is checked on its own.
- R5: In single mode, `s_sel` values 0 to 3 pick R2 to R5 as the pointer. R8 is the index. `mod_en` has no effect.
- R6: In single mode, `s_upd`=1 writes back the pointer plus the step, and `s_upd`=2 writes back the pointer plus R8. In both cases the old value is issued. The step is 2 when `s_long`=0 and 4 when `s_long`=1.
- R7: In single mode, `s_upd`=3 subtracts the step. The decremented value is both the address issued and the value written back.
- R8: A word address in single mode is issued with bit 0 forced to 0. A longword address whose two low bits are not 00 raises `addr_err`, and no write-back takes place. Otherwise the longword address is issued unchanged.
- R9: A paired operation makes no single-mode write-back, and a single operation makes no paired write-back. `s_upd`=0 and paired codes 0 and 3 assert no write-back enable.
- R10: The configuration port decodes `cfg_sel` as follows: 2 to 9 select R2 to R9; 10 and 11 select the X start and end limits; 12 and 13 select the Y start and end limits; all other values are ignored. If an operation writes back to the same register on the same edge, the write-back wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 4 | Configuration target |
| cfg_data | input | AW | Configuration value |
| op_valid | input | 1 | Operation issued this cycle |
| op_single | input | 1 | 1 = single mode, 0 = paired mode |
| mod_en | input | 1 | Modulo wrap enable (paired mode only) |
| x_sel | input | 1 | X pointer select |
| x_upd | input | 2 | X update code |
| y_sel | input | 1 | Y pointer select |
| y_upd | input | 2 | Y update code |
| s_sel | input | 2 | Single pointer select |
| s_upd | input | 2 | Single update code |
| s_long | input | 1 | Longword transfer |
| x_addr | output | AW | X bus address |
| y_addr | output | AW | Y bus address |
| s_addr | output | AW | Shared bus address |
| x_wb_en | output | 1 | X write-back enable |
| x_wb_reg | output | 4 | X write-back register number |
| x_wb_data | output | AW | X write-back value |
| y_wb_en | output | 1 | Y write-back enable |
| y_wb_reg | output | 4 | Y write-back register number |
| y_wb_data | output | AW | Y write-back value |
| s_wb_en | output | 1 | Single write-back enable |
| s_wb_reg | output | 4 | Single write-back register number |
| s_wb_data | output | AW | Single write-back value |
| addr_err | output | 1 | Misaligned longword |

## Verification
The bench builds the block with its default address width of 16 bits. At that width, the window limits, the index offsets and the wrap comparisons can all be chosen by hand as readable hexadecimal values. Each landed pointer is read back through a longword operation with no update, which issues the raw register value. This lets the bench confirm write-backs, suppressed write-backs and cleared modulo limits at the ports.

// File: rtl/dsp_agu.sv
module dsp_agu #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_we,
  input  logic [3:0]    cfg_sel,
  input  logic [AW-1:0] cfg_data,
  input  logic          op_valid,
  input  logic          op_single,
  input  logic          mod_en,
  input  logic          x_sel,
  input  logic [1:0]    x_upd,
  input  logic          y_sel,
  input  logic [1:0]    y_upd,
  input  logic [1:0]    s_sel,
  input  logic [1:0]    s_upd,
  input  logic          s_long,
  output logic [AW-1:0] x_addr,
  output logic [AW-1:0] y_addr,
  output logic [AW-1:0] s_addr,
  output logic          x_wb_en,
  output logic [3:0]    x_wb_reg,
  output logic [AW-1:0] x_wb_data,
  output logic          y_wb_en,
  output logic [3:0]    y_wb_reg,
  output logic [AW-1:0] y_wb_data,
  output logic          s_wb_en,
  output logic [3:0]    s_wb_reg,
  output logic [AW-1:0] s_wb_data,
  output logic          addr_err
);

  localparam logic [AW-1:0] STEP_W = AW'(2);
  localparam logic [AW-1:0] STEP_L = AW'(4);

  logic [9:2][AW-1:0] rf;
  logic [AW-1:0] xs, xe, ys, ye;

  function automatic logic [AW-1:0] wrap(input logic [AW-1:0] nv, st, en, input logic m);
    return (m && nv > en) ? st : nv;
  endfunction

  logic [AW-1:0] x_ptr, y_ptr, s_ptr, s_step, s_dec, s_eff;
  logic xy_op, s_op;

  assign xy_op = op_valid && !op_single;
  assign s_op  = op_valid && op_single;

  assign x_wb_reg  = x_sel ? 4'd5 : 4'd4;
  assign y_wb_reg  = y_sel ? 4'd7 : 4'd6;
  assign s_wb_reg  = {2'b00, s_sel} + 4'd2;
  assign x_ptr     = rf[x_wb_reg];
  assign y_ptr     = rf[y_wb_reg];
  assign s_ptr     = rf[s_wb_reg];

  assign x_addr    = {x_ptr[AW-1:1], 1'b0};
  assign y_addr    = {y_ptr[AW-1:1], 1'b0};
  assign x_wb_data = wrap((x_upd == 2'd2) ? x_ptr + rf[8] : x_ptr + STEP_W, xs, xe, mod_en);
  assign y_wb_data = wrap((y_upd == 2'd2) ? y_ptr + rf[9] : y_ptr + STEP_W, ys, ye, mod_en);
  assign x_wb_en   = xy_op && (x_upd == 2'd1 || x_upd == 2'd2);
  assign y_wb_en   = xy_op && (y_upd == 2'd1 || y_upd == 2'd2);

  assign s_step    = s_long ? STEP_L : STEP_W;
  assign s_dec     = s_ptr - s_step;
  assign s_eff     = (s_upd == 2'd3) ? s_dec : s_ptr;
  assign s_addr    = s_long ? s_eff : {s_eff[AW-1:1], 1'b0};
  assign addr_err  = s_op && s_long && (s_eff[1:0] != 2'b00);
  assign s_wb_en   = s_op && (s_upd != 2'd0) && !(s_long && s_eff[1:0] != 2'b00);
  assign s_wb_data = (s_upd == 2'd3) ? s_dec :
                     (s_upd == 2'd2) ? s_ptr + rf[8] : s_ptr + s_step;

  always_ff @(posedge clk) begin
    if (rst) begin
      rf <= '0;
      xs <= '0;
      xe <= '0;
      ys <= '0;
      ye <= '0;
    end else begin
      if (cfg_we) begin
        case (cfg_sel)
          4'd2, 4'd3, 4'd4, 4'd5, 4'd6, 4'd7, 4'd8, 4'd9: rf[cfg_sel] <= cfg_data;
          4'd10: xs <= cfg_data;
          4'd11: xe <= cfg_data;
          4'd12: ys <= cfg_data;
          4'd13: ye <= cfg_data;
          default: ;
        endcase
      end
      if (x_wb_en) rf[x_wb_reg] <= x_wb_data;
      if (y_wb_en) rf[y_wb_reg] <= y_wb_data;
      if (s_wb_en) rf[s_wb_reg] <= s_wb_data;
    end
  end

  AST_X_WB_LANDS: assert property (@(posedge clk) disable iff (rst)
    x_wb_en |=> rf[$past(x_wb_reg)] == $past(x_wb_data)); // R3
  AST_S_WB_LANDS: assert property (@(posedge clk) disable iff (rst)
    s_wb_en |=> rf[$past(s_wb_reg)] == $past(s_wb_data)); // R6
  AST_X_IN_WINDOW: assert property (@(posedge clk) disable iff (rst)
    (x_wb_en && mod_en) |-> (x_wb_data <= xe || x_wb_data == xs)); // R4
  AST_Y_IN_WINDOW: assert property (@(posedge clk) disable iff (rst)
    (y_wb_en && mod_en) |-> (y_wb_data <= ye || y_wb_data == ys)); // R4
  AST_ERR_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (addr_err && !cfg_we) |=> $stable(rf)); // R8
  AST_ERR_LONG_ONLY: assert property (@(posedge clk) disable iff (rst)
    addr_err |-> (op_valid && op_single && s_long)); // R8
  AST_MODE_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(s_wb_en && (x_wb_en || y_wb_en))); // R9

endmodule

// File: tb/dsp_agu_tb.sv
`timescale 1ns/1ps
module dsp_agu_tb;
  localparam int AW = 16;

  logic clk = 0, rst = 1;
  logic cfg_we = 0; logic [3:0] cfg_sel = 0; logic [AW-1:0] cfg_data = 0;
  logic op_valid = 0, op_single = 0, mod_en = 0, x_sel = 0, y_sel = 0, s_long = 0;
  logic [1:0] x_upd = 0, y_upd = 0, s_sel = 0, s_upd = 0;
  logic [AW-1:0] x_addr, y_addr, s_addr, x_wb_data, y_wb_data, s_wb_data;
  logic x_wb_en, y_wb_en, s_wb_en, addr_err;
  logic [3:0] x_wb_reg, y_wb_reg, s_wb_reg;
  int nchk = 0, nerr = 0, cyc = 0;

  always #4 clk = ~clk;

  dsp_agu #(.AW(AW)) u_dut (.*);

  // {single, sel[1:0], upd[1:0], long, mod, ptr[15:0], ea[15:0], wben, wbd[15:0], err}
  localparam logic [56:0] VEC [15] = '{
    {1'b0,2'd0,2'd0,1'b0,1'b0,16'h1234,16'h1234,1'b0,16'h0000,1'b0}, // R2 R9 none
    {1'b0,2'd1,2'd1,1'b0,1'b0,16'h0101,16'h0100,1'b1,16'h0103,1'b0}, // R2 R3 +2
    {1'b0,2'd0,2'd2,1'b0,1'b0,16'h0050,16'h0050,1'b1,16'h0060,1'b0}, // R3 +R8
    {1'b0,2'd1,2'd1,1'b0,1'b1,16'h010E,16'h010E,1'b1,16'h0100,1'b0}, // R4 wrap
    {1'b0,2'd0,2'd2,1'b0,1'b1,16'h0100,16'h0100,1'b1,16'h0100,1'b0}, // R4 wrap index
    {1'b0,2'd0,2'd1,1'b0,1'b1,16'h010C,16'h010C,1'b1,16'h010E,1'b0}, // R4 no wrap
    {1'b1,2'd0,2'd1,1'b0,1'b0,16'h0300,16'h0300,1'b1,16'h0302,1'b0}, // R5 R6 word
    {1'b1,2'd3,2'd1,1'b1,1'b0,16'h0400,16'h0400,1'b1,16'h0404,1'b0}, // R6 long
    {1'b1,2'd1,2'd2,1'b1,1'b0,16'h0500,16'h0500,1'b1,16'h0510,1'b0}, // R6 +R8
    {1'b1,2'd2,2'd3,1'b0,1'b0,16'h0600,16'h05FE,1'b1,16'h05FE,1'b0}, // R7 word
    {1'b1,2'd0,2'd3,1'b1,1'b0,16'h0600,16'h05FC,1'b1,16'h05FC,1'b0}, // R7 long
    {1'b1,2'd1,2'd1,1'b1,1'b0,16'h0702,16'h0702,1'b0,16'h0000,1'b1}, // R8 misaligned
    {1'b1,2'd0,2'd1,1'b0,1'b1,16'h010E,16'h010E,1'b1,16'h0110,1'b0}, // R5 no modulo
    {1'b1,2'd2,2'd0,1'b1,1'b0,16'h0801,16'h0801,1'b0,16'h0000,1'b1}, // R8 no update
    {1'b1,2'd3,2'd1,1'b0,1'b0,16'h0901,16'h0900,1'b1,16'h0903,1'b0}  // R8 word LSB
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      nerr++; nchk++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  task automatic cfg(input logic [3:0] sel, input logic [AW-1:0] d);
    @(negedge clk);
    cfg_we = 1; cfg_sel = sel; cfg_data = d;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic idle();
    op_valid = 0; op_single = 0; mod_en = 0; x_upd = 0; y_upd = 0; s_upd = 0;
  endtask

  // raw readback of R2..R5 through a longword access with no update
  task automatic rd(input int r, input logic [AW-1:0] exp, input string tag);
    @(negedge clk);
    op_valid = 1; op_single = 1; s_long = 1; s_upd = 0; s_sel = 2'(r - 2);
    #1 chk(tag, s_addr, exp);
    @(negedge clk);
    idle();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    for (int r = 2; r <= 5; r++) rd(r, 16'h0000, "R1 reset pointer");
    @(negedge clk);
    op_valid = 1; x_sel = 1; y_sel = 1;
    #1 chk("R1 reset y", y_addr, 16'h0000);
    chk("R1 reset x", x_addr, 16'h0000);
    idle();

    cfg(4'd8, 16'h0010); cfg(4'd9, 16'h0020);
    cfg(4'd10, 16'h0100); cfg(4'd11, 16'h010F);
    cfg(4'd12, 16'h0200); cfg(4'd13, 16'h020F);

    for (int i = 0; i < 15; i++) begin
      logic [56:0] v;
      int r;
      v = VEC[i];
      r = v[56] ? 2 + int'(v[55:54]) : 4 + int'(v[55:54]);
      cfg(4'(r), v[49:34]);
      @(negedge clk);
      op_valid = 1; op_single = v[56]; mod_en = v[50];
      x_sel = v[54]; x_upd = v[53:52]; y_upd = 0;
      s_sel = v[55:54]; s_upd = v[53:52]; s_long = v[51];
      #1;
      if (v[56]) begin
        chk($sformatf("vec%0d R5 addr", i), s_addr, v[33:18]);
        chk($sformatf("vec%0d R9 wb_en", i), s_wb_en, v[17]);
        chk($sformatf("vec%0d R8 err", i), addr_err, v[0]);
        chk($sformatf("vec%0d R9 xy quiet", i), {x_wb_en, y_wb_en}, 2'b00);
        if (v[17]) begin
          chk($sformatf("vec%0d R6 wb", i), s_wb_data, v[16:1]);
          chk($sformatf("vec%0d R5 reg", i), s_wb_reg, 4'(r));
        end
      end else begin
        chk($sformatf("vec%0d R2 addr", i), x_addr, v[33:18]);
        chk($sformatf("vec%0d R9 wb_en", i), x_wb_en, v[17]);
        chk($sformatf("vec%0d R9 single quiet", i), s_wb_en, 1'b0);
        if (v[17]) begin
          chk($sformatf("vec%0d R3 wb", i), x_wb_data, v[16:1]);
          chk($sformatf("vec%0d R2 reg", i), x_wb_reg, 4'(r));
        end
      end
      @(negedge clk);
      idle();
      rd(r, v[17] ? v[16:1] : v[49:34], $sformatf("vec%0d R3 landed", i));
    end

    // R3 R4: both sides update on the same edge, Y wraps independently
    cfg(4'd4, 16'h0030); cfg(4'd7, 16'h020E);
    @(negedge clk);
    op_valid = 1; op_single = 0; mod_en = 1;
    x_sel = 0; x_upd = 2; y_sel = 1; y_upd = 1;
    #1 chk("R2 y addr", y_addr, 16'h020E);
    chk("R4 y wrap", y_wb_data, 16'h0200);
    chk("R4 x unwrapped", x_wb_data, 16'h0040);
    chk("R3 both en", {x_wb_en, y_wb_en}, 2'b11);
    chk("R2 y reg", y_wb_reg, 4'd7);
    @(negedge clk);
    idle();
    @(negedge clk);
    op_valid = 1; y_sel = 1; x_sel = 0; y_upd = 2'd3;
    #1 chk("R3 y landed", y_addr, 16'h0200);
    chk("R3 x landed", x_addr, 16'h0040);
    chk("R3 code3 no wb", y_wb_en, 1'b0);
    idle();

    // R3 Y index add uses R9
    cfg(4'd6, 16'h0300);
    @(negedge clk);
    op_valid = 1; y_sel = 0; y_upd = 2;
    #1 chk("R3 y index R9", y_wb_data, 16'h0320);
    idle();

    // R10 write-back wins over configuration
    cfg(4'd4, 16'h0040);
    @(negedge clk);
    cfg_we = 1; cfg_sel = 4'd4; cfg_data = 16'hAAAA;
    op_valid = 1; op_single = 0; x_sel = 0; x_upd = 1;
    @(negedge clk);
    cfg_we = 0; idle();
    rd(4, 16'h0042, "R10 wb priority");
    cfg(4'd15, 16'h5555);
    rd(4, 16'h0042, "R10 ignored select");

    // R1 reset mid-run clears pointers and modulo limits
    cfg(4'd2, 16'h1111);
    @(negedge clk); rst = 1;
    @(negedge clk); rst = 0;
    rd(2, 16'h0000, "R1 pointer cleared");
    cfg(4'd4, 16'h0010);
    @(negedge clk);
    op_valid = 1; op_single = 0; mod_en = 1; x_sel = 0; x_upd = 1;
    #1 chk("R1 limits cleared", x_wb_data, 16'h0000);
    idle();

    finish_run();
  end
endmodule